// File: doc/BRIEF.md
# Three-Stage Pipelined Instruction Sequencer

This block is a small in-order core that overlaps three stages: fetch, decode and execute. Fetch sends the program counter to a synchronous instruction memory. Decode works on the word that memory returns one cycle later. Execute reads the register file, uses one shared adder and writes the result back.

The instruction set has four classes:

- register add, taking a register or an immediate as the second operand;
- word load;
- branch that records a return address;
- one reserved code, which does nothing.

Each class stays in execute for a different number of cycles. A small controller decides how long an instruction stays there. It can freeze the two earlier stages, or discard their contents after a branch.

The execute controller is one state machine with five states:

- `XS_FIRST` is the first execute cycle of every instruction, and also the idle state when execute is empty.
- `XS_LD_ISSUE` and `XS_LD_DATA` are the second and third cycles of a load.
- `XS_BL_LINK` and `XS_BL_ADJ` are the two refill cycles of a branch.

Transitions:

- `XS_FIRST` goes to `XS_LD_ISSUE` when a valid load is in execute.
- `XS_FIRST` goes to `XS_BL_LINK` when a valid branch is in execute.
- In every other case `XS_FIRST` stays where it is.
- The load path runs `XS_LD_ISSUE` → `XS_LD_DATA` → `XS_FIRST`.
- The branch path runs `XS_BL_LINK` → `XS_BL_ADJ` → `XS_FIRST`.

Every register write appears on a retire port in the cycle it happens. The address of the instruction in execute is also visible on the ports. Together these let an integrator trace timing per instruction class.

Top module: `seq3_core`

## Requirements
- R1: While reset is high, the PC is cleared to 0 and both pipeline stages are emptied. In cycle 0 after reset is released, `imem_addr` is 0. No instruction is in execute in cycles 0 and 1, and the word at address 0 is in execute in cycle 2.
- R2: The operation code is in bits [31:30]. Code 00 is an add: rd[27:24] = rn[23:20] + operand. The operand is the zero-extended [15:0] when bit 29 is 1, and rm[19:16] when bit 29 is 0. An add stays one cycle in execute, and its write appears on `wb_valid`/`wb_reg`/`wb_data` in that cycle. Consecutive adds execute one per cycle.
- R3: Reading register index 15 as an operand gives the address of the instruction in execute plus 8. Instruction addresses step by 4.
- R4: Code 01 is a load.
  - Cycle 1 of execute computes the address rn + zero-extended [15:0], plus rm when bit 29 is 1.
  - Cycle 2 drives that address on `dmem_addr`, with `dmem_ren` high for exactly that one cycle.
  - Cycle 3 writes `dmem_rdata` to rd.
- R5: During the first two load cycles, `imem_addr` stays at the address of the word held in decode, and the PC does not advance. The next instruction enters execute in the cycle after the load's third cycle.
- R6: Code 10 is a branch. Its target is the branch's own address + 8 + the signed byte offset in [28:0].
  - Words fetched after the branch never execute.
  - `imem_addr` shows the target in the next cycle.
  - The target instruction enters execute three cycles after the branch entered.
- R7: In its second execute cycle, a branch writes register 14 with its own address + 8. In its third cycle it writes register 14 again with that value minus 4.
- R8: A write aimed at register 15 is dropped. It shows no retire, and the next sequential instruction follows in the next cycle.
- R9: Code 11 stays one cycle in execute and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | XLEN | Byte address sent to instruction memory |
| imem_rdata | input | 32 | Instruction word, one cycle after its address |
| dmem_addr | output | XLEN | Load byte address |
| dmem_ren | output | 1 | High in the address cycle of a load |
| dmem_rdata | input | XLEN | Load data, one cycle after the address cycle |
| wb_valid | output | 1 | A register is written this cycle |
| wb_reg | output | RIW | Index of the register written |
| wb_data | output | XLEN | Value written |
| ex_valid_o | output | 1 | An instruction occupies execute |
| ex_pc_o | output | XLEN | Address of the instruction in execute |

## Verification
The main trace is a single program with several patterns, checked against a per-cycle expected table:

- **Back-to-back immediate and register adds** separate the two operand selections.
- **An add that reads register 15** exposes the +8 offset.
- **Two loads, one using only the immediate and one using both register and immediate offsets,** check address formation. They also check that fetch holds for the stall cycles, shown by a held `imem_addr`.
- **An add that consumes the data just loaded** checks that the load's writeback lands before the next instruction reads it.
- **A forward branch and a backward branch** each check the target, the discarded words and the two-step return address.
- **A write aimed at register 15 and a reserved code** show that nothing is written.

A directed reset applied in the middle of the run checks that execution restarts from address 0 with the same timing.

// File: rtl/seq3_pkg.sv
package seq3_pkg;

    localparam int ILEN = 32;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_LDR = 2'b01,
        OP_BL  = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        XS_FIRST,
        XS_LD_ISSUE,
        XS_LD_DATA,
        XS_BL_LINK,
        XS_BL_ADJ
    } xstate_e;

    // operand routing for the single adder
    typedef enum logic [2:0] {
        AS_NONE,
        AS_ADD,
        AS_LD,
        AS_BR,
        AS_LINK,
        AS_ADJ
    } asel_e;

    typedef struct packed {
        logic  hold_front;  // freeze fetch and decode
        logic  ex_done;     // execute accepts the decode word at this edge
        logic  flush;       // redirect fetch to the adder result
        logic  ld_latch;    // capture load address
        logic  dmem_ren;
        asel_e asel;
        logic  wb_en;
        logic  wb_mem;      // write data comes from the data port
        logic  wb_link;     // write goes to the link register
    } ctl_t;

endpackage

// File: rtl/seq3_alu.sv
module seq3_alu #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    input  logic            sub,
    output logic [XLEN-1:0] y
);

    always_comb begin
        if (sub) y = a - b;
        else     y = a + b + c;
    end

endmodule

// File: rtl/seq3_regfile.sv
module seq3_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    parameter int RIW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RIW-1:0]  widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [RIW-1:0]  ra_idx,
    input  logic [RIW-1:0]  rb_idx,
    input  logic [XLEN-1:0] pc_op,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val
);

    localparam logic [RIW-1:0] PCI = RIW'(NREG - 1);

    logic [XLEN-1:0] regs [0:NREG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && widx != PCI) begin
            regs[widx] <= wdata;
        end
    end

    always_comb begin
        ra_val = (ra_idx == PCI) ? pc_op : regs[ra_idx];
        rb_val = (rb_idx == PCI) ? pc_op : regs[rb_idx];
    end

endmodule

// File: rtl/seq3_exec_fsm.sv
module seq3_exec_fsm
    import seq3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ex_valid,
    input  op_e  ex_op,
    output ctl_t ctl
);

    xstate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= XS_FIRST;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            XS_FIRST: begin
                if (!ex_valid) begin
                    ctl.ex_done = 1'b1;
                end else begin
                    unique case (ex_op)
                        OP_ADD: begin
                            ctl.asel    = AS_ADD;
                            ctl.wb_en   = 1'b1;
                            ctl.ex_done = 1'b1;
                        end
                        OP_LDR: begin
                            ctl.asel       = AS_LD;
                            ctl.ld_latch   = 1'b1;
                            ctl.hold_front = 1'b1;
                            state_d        = XS_LD_ISSUE;
                        end
                        OP_BL: begin
                            ctl.asel  = AS_BR;
                            ctl.flush = 1'b1;
                            state_d   = XS_BL_LINK;
                        end
                        OP_RSV: begin
                            ctl.ex_done = 1'b1;
                        end
                        default: ctl.ex_done = 1'b1;
                    endcase
                end
            end
            XS_LD_ISSUE: begin
                ctl.hold_front = 1'b1;
                ctl.dmem_ren   = 1'b1;
                state_d        = XS_LD_DATA;
            end
            XS_LD_DATA: begin
                ctl.wb_en   = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.ex_done = 1'b1;
                state_d     = XS_FIRST;
            end
            XS_BL_LINK: begin
                ctl.asel    = AS_LINK;
                ctl.wb_en   = 1'b1;
                ctl.wb_link = 1'b1;
                state_d     = XS_BL_ADJ;
            end
            XS_BL_ADJ: begin
                ctl.asel    = AS_ADJ;
                ctl.wb_en   = 1'b1;
                ctl.wb_link = 1'b1;
                ctl.ex_done = 1'b1;
                state_d     = XS_FIRST;
            end
            default: state_d = XS_FIRST;
        endcase
    end

endmodule

// File: rtl/seq3_core.sv
module seq3_core
    import seq3_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int RIW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_ren,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            wb_valid,
    output logic [RIW-1:0]  wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            ex_valid_o,
    output logic [XLEN-1:0] ex_pc_o
);

    localparam logic [RIW-1:0]  PCI     = RIW'(NREG - 1);
    localparam logic [RIW-1:0]  LINKI   = RIW'(NREG - 2);
    localparam logic [XLEN-1:0] STEP    = XLEN'(4);
    localparam logic [XLEN-1:0] PC_AHEAD = XLEN'(8);

    logic [XLEN-1:0] pc_q, fa_addr_q, ex_addr_q, ld_addr_q;
    logic            fa_valid_q, ex_valid_q;
    logic [ILEN-1:0] ex_instr_q;

    ctl_t ctl;
    op_e  ex_op;

    logic [RIW-1:0]  f_rd, f_rn, f_rm, ra_idx;
    logic            f_alt;
    logic [XLEN-1:0] f_imm, f_boff, pc_op;
    logic [XLEN-1:0] ra_val, rb_val;
    logic [XLEN-1:0] alu_a, alu_b, alu_c, alu_y;
    logic            alu_sub;

    // instruction fields
    assign ex_op  = op_e'(ex_instr_q[31:30]);
    assign f_alt  = ex_instr_q[29];
    assign f_rd   = ex_instr_q[24 +: RIW];
    assign f_rn   = ex_instr_q[20 +: RIW];
    assign f_rm   = ex_instr_q[16 +: RIW];
    assign f_imm  = {{(XLEN-16){1'b0}}, ex_instr_q[15:0]};
    assign f_boff = {{(XLEN-29){ex_instr_q[28]}}, ex_instr_q[28:0]};
    assign pc_op  = ex_addr_q + PC_AHEAD;

    seq3_exec_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ex_valid (ex_valid_q),
        .ex_op    (ex_op),
        .ctl      (ctl)
    );

    assign ra_idx = (ctl.asel == AS_ADJ) ? LINKI : f_rn;

    seq3_regfile #(.XLEN(XLEN), .NREG(NREG), .RIW(RIW)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (wb_valid),
        .widx   (wb_reg),
        .wdata  (wb_data),
        .ra_idx (ra_idx),
        .rb_idx (f_rm),
        .pc_op  (pc_op),
        .ra_val (ra_val),
        .rb_val (rb_val)
    );

    always_comb begin
        alu_a   = '0;
        alu_b   = '0;
        alu_c   = '0;
        alu_sub = 1'b0;
        unique case (ctl.asel)
            AS_ADD:  begin alu_a = ra_val; alu_b = f_alt ? f_imm : rb_val; end
            AS_LD:   begin alu_a = ra_val; alu_b = f_imm; alu_c = f_alt ? rb_val : '0; end
            AS_BR:   begin alu_a = pc_op;  alu_b = f_boff; end
            AS_LINK: begin alu_a = pc_op; end
            AS_ADJ:  begin alu_a = ra_val; alu_b = STEP; alu_sub = 1'b1; end
            default: ;
        endcase
    end

    seq3_alu #(.XLEN(XLEN)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .c   (alu_c),
        .sub (alu_sub),
        .y   (alu_y)
    );

    assign wb_reg   = ctl.wb_link ? LINKI : f_rd;
    assign wb_valid = ctl.wb_en && (wb_reg != PCI);
    assign wb_data  = ctl.wb_mem ? dmem_rdata : alu_y;

    // re-present the decode word while the front end is frozen
    assign imem_addr  = ctl.hold_front ? fa_addr_q : pc_q;
    assign dmem_addr  = ld_addr_q;
    assign dmem_ren   = ctl.dmem_ren;
    assign ex_valid_o = ex_valid_q;
    assign ex_pc_o    = ex_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            fa_addr_q  <= '0;
            fa_valid_q <= 1'b0;
            ex_valid_q <= 1'b0;
            ex_instr_q <= '0;
            ex_addr_q  <= '0;
            ld_addr_q  <= '0;
        end else begin
            if (ctl.ld_latch) ld_addr_q <= alu_y;
            if (ctl.flush) begin
                pc_q       <= alu_y;
                fa_valid_q <= 1'b0;
            end else if (!ctl.hold_front) begin
                pc_q       <= pc_q + STEP;
                fa_addr_q  <= pc_q;
                fa_valid_q <= 1'b1;
            end
            if (ctl.ex_done) begin
                ex_valid_q <= fa_valid_q;
                ex_instr_q <= imem_rdata;
                ex_addr_q  <= fa_addr_q;
            end
        end
    end

endmodule

// File: rtl/seq3_core_chk.sv
module seq3_core_chk #(
    parameter int XLEN = 32,
    parameter int RIW  = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic            dmem_ren,
    input logic            wb_valid,
    input logic [RIW-1:0]  wb_reg,
    input logic [XLEN-1:0] wb_data,
    input logic            ex_valid_o,
    input logic [XLEN-1:0] ex_pc_o
);

    localparam logic [RIW-1:0] PCI   = {RIW{1'b1}};
    localparam logic [RIW-1:0] LINKI = PCI - 1'b1;

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ex_valid_o && imem_addr == '0));

    // R4
    load_issue_once_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_ren |=> (!dmem_ren && wb_valid && $stable(ex_pc_o)));

    // R5
    load_hold_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_ren |-> $stable(imem_addr));

    // R8
    no_pc_write_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_reg != PCI));

    // R7
    link_adjust_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && wb_reg == LINKI && $past(wb_valid && wb_reg == LINKI)
         && ex_valid_o && $stable(ex_pc_o))
        |-> (wb_data == $past(wb_data) - XLEN'(4)));

endmodule

bind seq3_core seq3_core_chk #(.XLEN(XLEN), .RIW(RIW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .dmem_ren   (dmem_ren),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .wb_data    (wb_data),
    .ex_valid_o (ex_valid_o),
    .ex_pc_o    (ex_pc_o)
);

// File: tb/seq3_core_tb_top.sv
`timescale 1ns/100ps
module seq3_core_tb_top;

    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [XLEN-1:0] imem_addr, dmem_addr, wb_data, ex_pc_o;
    logic [31:0]     imem_rdata;
    logic [XLEN-1:0] dmem_rdata;
    logic            dmem_ren, wb_valid, ex_valid_o;
    logic [3:0]      wb_reg;

    seq3_core dut_i (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_ren(dmem_ren), .dmem_rdata(dmem_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
        .ex_valid_o(ex_valid_o), .ex_pc_o(ex_pc_o)
    );

    logic [31:0] imem [0:255];
    logic [31:0] dmem [0:255];

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[9:2]];
        dmem_rdata <= dmem[dmem_addr[9:2]];
    end

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    logic        lg_exv [0:63];
    logic [31:0] lg_pc  [0:63];
    logic        lg_wbv [0:63];
    logic [3:0]  lg_wbr [0:63];
    logic [31:0] lg_wbd [0:63];
    logic [31:0] lg_ia  [0:63];
    logic        lg_drn [0:63];
    logic [31:0] lg_da  [0:63];

    always @(negedge clk) begin
        if (!rst && cyc < 64) begin
            lg_exv[cyc] = ex_valid_o;
            lg_pc[cyc]  = ex_pc_o;
            lg_wbv[cyc] = wb_valid;
            lg_wbr[cyc] = wb_reg;
            lg_wbd[cyc] = wb_data;
            lg_ia[cyc]  = imem_addr;
            lg_drn[cyc] = dmem_ren;
            lg_da[cyc]  = dmem_addr;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_add(input int rd, input int rn, input int rm);
        return {2'b00, 1'b0, 1'b0, 4'(rd), 4'(rn), 4'(rm), 16'h0};
    endfunction
    function automatic logic [31:0] enc_addi(input int rd, input int rn, input int imm);
        return {2'b00, 1'b1, 1'b0, 4'(rd), 4'(rn), 4'h0, 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_ldr(input int rd, input int rn, input int rm,
                                            input bit use_rm, input int imm);
        return {2'b01, use_rm, 1'b0, 4'(rd), 4'(rn), 4'(rm), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_bl(input int off);
        return {2'b10, 1'b0, 29'(off)};
    endfunction

    typedef struct packed {
        logic [7:0]  cy;
        logic        exv;
        logic [31:0] pc;
        logic        wbv;
        logic [3:0]  rg;
        logic [31:0] dat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [0:NV-1] = '{
        '{8'd0,  1'b0, 32'd0,  1'b0, 4'd0,  32'd0,          8'd1}, // R1
        '{8'd1,  1'b0, 32'd0,  1'b0, 4'd0,  32'd0,          8'd1}, // R1
        '{8'd2,  1'b1, 32'd0,  1'b1, 4'd1,  32'd5,          8'd1}, // R1
        '{8'd3,  1'b1, 32'd4,  1'b1, 4'd2,  32'h105,        8'd2}, // R2 immediate
        '{8'd4,  1'b1, 32'd8,  1'b1, 4'd3,  32'h10A,        8'd2}, // R2 register
        '{8'd5,  1'b1, 32'd12, 1'b1, 4'd4,  32'd20,         8'd3}, // R3
        '{8'd6,  1'b1, 32'd16, 1'b0, 4'd0,  32'd0,          8'd4}, // R4 addr calc
        '{8'd7,  1'b1, 32'd16, 1'b0, 4'd0,  32'd0,          8'd4}, // R4 issue
        '{8'd8,  1'b1, 32'd16, 1'b1, 4'd5,  32'hD000_0080,  8'd4}, // R4 data
        '{8'd9,  1'b1, 32'd20, 1'b0, 4'd0,  32'd0,          8'd5}, // R5
        '{8'd11, 1'b1, 32'd20, 1'b1, 4'd6,  32'hD000_0044,  8'd4}, // R4
        '{8'd12, 1'b1, 32'd24, 1'b1, 4'd7,  32'hA000_00C4,  8'd5}, // R5 dependent add
        '{8'd13, 1'b1, 32'd28, 1'b0, 4'd0,  32'd0,          8'd6}, // R6
        '{8'd14, 1'b1, 32'd28, 1'b1, 4'd14, 32'd36,         8'd7}, // R7
        '{8'd15, 1'b1, 32'd28, 1'b1, 4'd14, 32'd32,         8'd7}, // R7
        '{8'd16, 1'b1, 32'd64, 1'b1, 4'd10, 32'd32,         8'd6}, // R6 target
        '{8'd17, 1'b1, 32'd68, 1'b0, 4'd0,  32'd0,          8'd8}, // R8
        '{8'd18, 1'b1, 32'd72, 1'b0, 4'd0,  32'd0,          8'd9}, // R9
        '{8'd19, 1'b1, 32'd76, 1'b0, 4'd0,  32'd0,          8'd9}, // R9
        '{8'd20, 1'b1, 32'd76, 1'b1, 4'd14, 32'd84,         8'd7}, // R7
        '{8'd21, 1'b1, 32'd76, 1'b1, 4'd14, 32'd80,         8'd7}, // R7
        '{8'd22, 1'b1, 32'd48, 1'b1, 4'd11, 32'd80,         8'd6}, // R6 backward
        '{8'd23, 1'b1, 32'd52, 1'b0, 4'd0,  32'd0,          8'd6}  // R6
    };

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            imem[i] = enc_addi(9, 0, 16'h99);
            dmem[i] = 32'hD000_0000 + i;
        end
        imem[0]  = enc_addi(1, 0, 5);
        imem[1]  = enc_addi(2, 1, 16'h100);
        imem[2]  = enc_add(3, 1, 2);
        imem[3]  = enc_add(4, 15, 0);
        imem[4]  = enc_ldr(5, 0, 0, 1'b0, 16'h200);
        imem[5]  = enc_ldr(6, 1, 3, 1'b1, 1);
        imem[6]  = enc_add(7, 6, 5);
        imem[7]  = enc_bl(28);
        imem[8]  = enc_addi(8, 0, 16'h77);
        imem[12] = enc_addi(11, 14, 0);
        imem[13] = enc_bl(-8);
        imem[16] = enc_add(10, 14, 0);
        imem[17] = enc_addi(15, 0, 1);
        imem[18] = 32'hC000_0000;
        imem[19] = enc_bl(-36);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (30) @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            automatic int c = int'(VEC[i].cy);
            automatic bit ok = (lg_exv[c] == VEC[i].exv) && (lg_wbv[c] == VEC[i].wbv);
            if (VEC[i].exv) ok = ok && (lg_pc[c] == VEC[i].pc);
            if (VEC[i].wbv) ok = ok && (lg_wbr[c] == VEC[i].rg) && (lg_wbd[c] == VEC[i].dat);
            chk(ok, $sformatf("R%0d", VEC[i].req),
                $sformatf("cycle %0d pc/wb", c),
                {lg_exv[c], lg_wbv[c], 2'b00, lg_wbr[c], lg_pc[c][7:0], lg_wbd[c][15:0]},
                {VEC[i].exv, VEC[i].wbv, 2'b00, VEC[i].rg, VEC[i].pc[7:0], VEC[i].dat[15:0]});
        end

        // R1 fetch starts at address 0
        chk(lg_ia[0] == 32'd0, "R1", "imem_addr cycle 0", lg_ia[0], 32'd0);
        chk(lg_ia[1] == 32'd4, "R1", "imem_addr cycle 1", lg_ia[1], 32'd4);
        // R5 front end held during load
        chk(lg_ia[6] == 32'd20, "R5", "imem_addr cycle 6", lg_ia[6], 32'd20);
        chk(lg_ia[7] == 32'd20, "R5", "imem_addr cycle 7", lg_ia[7], 32'd20);
        chk(lg_ia[8] == 32'd24, "R5", "imem_addr cycle 8", lg_ia[8], 32'd24);
        // R4 data address phase
        chk(lg_drn[6] == 1'b0, "R4", "dmem_ren cycle 6", 32'(lg_drn[6]), 32'd0);
        chk(lg_drn[7] == 1'b1 && lg_da[7] == 32'h200, "R4", "dmem addr cycle 7",
            lg_da[7], 32'h200);
        chk(lg_drn[8] == 1'b0, "R4", "dmem_ren cycle 8", 32'(lg_drn[8]), 32'd0);
        chk(lg_drn[10] == 1'b1 && lg_da[10] == 32'h110, "R4", "dmem addr cycle 10",
            lg_da[10], 32'h110);
        // R6 refetch at target, discarded words never retire
        chk(lg_ia[14] == 32'd64, "R6", "imem_addr after branch", lg_ia[14], 32'd64);
        begin
            automatic int bad = 0;
            for (int c = 0; c < 30; c++)
                if (lg_wbv[c] && (lg_wbr[c] == 4'd8 || lg_wbr[c] == 4'd9)) bad++;
            chk(bad == 0, "R6", "writes from flushed words", 32'(bad), 32'd0);
        end

        // R1 reset in the middle of the run
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!ex_valid_o && !wb_valid, "R1", "execute empty in reset",
            {30'd0, ex_valid_o, wb_valid}, 32'd0);
        chk(imem_addr == 32'd0, "R1", "imem_addr in reset", imem_addr, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        repeat (7) @(posedge clk);
        #1;
        chk(!lg_exv[1] && lg_exv[2] && lg_pc[2] == 32'd0, "R1", "restart timing",
            lg_pc[2], 32'd0);
        chk(lg_wbv[2] && lg_wbr[2] == 4'd1 && lg_wbd[2] == 32'd5, "R1",
            "first write after restart", lg_wbd[2], 32'd5);
        chk(lg_wbv[5] && lg_wbd[5] == 32'd20, "R3", "pc operand after restart",
            lg_wbd[5], 32'd20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule